// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block divides a 32.768 kHz timebase, delivered as a one-cycle enable on the system clock, into periodic interrupt ticks. A 4-bit rate code sets the tick period. A 3-bit divider-control field can freeze and clear the divider. An enable bit gates whether ticks are issued at all. Each tick appears as a one-cycle pulse that sets the periodic flag in a status register. A second pulse in the same cycle asks the status logic to raise its interrupt summary bit and the interrupt line.

The divider is a free-running 15-bit counter, and its count advances on every timebase enable. A tick fires when the low bits of the incremented count, as many as the period needs, all become zero. Ticks therefore always land on multiples of the period. A change of rate code never restarts the divider, so the first tick under a new code falls on the next boundary of the new period.

Top module: `periodic_tick_gen`

## Requirements
- R1: After reset both outputs are low and the divider count is zero, so the first tick under a code of period P comes on the P-th timebase enable after reset is released.
- R2: Rate code 0 produces no ticks, whatever the other inputs are.
- R3: For rate codes 3 to 15, the period is 2^(code-1) timebase enables: code 3 gives 4, code 15 gives 16384.
- R4: Rate code 1 behaves as code 8 (period 128) and rate code 2 behaves as code 9 (period 256).
- R5: A tick fires exactly when the divider count, after its increment, is a multiple of the period. The divider is never restarted by a change of code or of enable, so no partial period is produced.
- R6: While the periodic enable is low, no tick is issued, but the divider keeps counting.
- R7: While bits 2 and 1 of the divider-control field are both 1, the divider is held at zero and no tick is issued. Other field values let the divider run.
- R8: Each tick is a pulse of exactly one clock cycle on pf_set_o. irq_req_o pulses in the same cycle.
- R9: In a cycle without a timebase enable, the divider does not advance and no tick is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_tick_i | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| rate_sel_i | input | 4 | Rate code; 0 disables ticks |
| div_ctl_i | input | 3 | Divider control; 3'b11x holds the divider in reset |
| pie_i | input | 1 | Periodic interrupt enable |
| pf_set_o | output | 1 | One-cycle pulse that sets the periodic flag |
| irq_req_o | output | 1 | One-cycle request to raise the interrupt summary and line |

## Verification
The only state the block holds is the divider count, and that state shows at the ports only through when ticks occur. A count that is off by one shows up at the next tick, which arrives one timebase enable early or late. A divider wrongly restarted on a code change shows as a tick out of phase with the boundaries the free-running count predicts. A wrong alias for codes 1 or 2, or a hold that fails to clear the count, moves every later tick, so a mismatch appears within one period of the stimulus that caused it. The bench keeps its own model of the free-running count and compares the expected pulse pattern with both outputs in every cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int DIV_W   = 15;
  localparam int CODE_W  = 4;
  localparam int CTL_W   = 3;
  localparam int SHIFT_W = 5;

  // Remap the rate code: 1 and 2 stand for 8 and 9, 0 stays 0.
  function automatic logic [CODE_W-1:0] remap_code(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] r;
    unique case (code)
      4'd1:    r = 4'd8;
      4'd2:    r = 4'd9;
      default: r = code;
    endcase
    return r;
  endfunction

  // Number of low divider bits that must roll over for one tick:
  // the period is 2**shift timebase enables.
  function automatic logic [SHIFT_W-1:0] period_shift(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] e;
    e = remap_code(code);
    if (e == '0) return '0;
    return SHIFT_W'(e) - SHIFT_W'(1);
  endfunction

  // Divider hold: both upper bits of the control field set.
  function automatic logic div_held(input logic [CTL_W-1:0] ctl);
    return ctl[CTL_W-1] & ctl[CTL_W-2];
  endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int CNT_W = pit_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] next_o
);

  logic [CNT_W-1:0] cnt_q;

  assign next_o  = cnt_q + CNT_W'(1);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= next_o;
  end

endmodule

// File: rtl/pit_rate_decode.sv
module pit_rate_decode
  import pit_pkg::*;
#(
  parameter int CNT_W = DIV_W
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              pie_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  mask_o
);

  logic [SHIFT_W-1:0] shift;

  assign shift    = period_shift(code_i);
  assign active_o = pie_i & (code_i != '0);

  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign mask_o[g] = (SHIFT_W'(g) < shift);
  end

endmodule

// File: rtl/pit_tick_gate.sv
module pit_tick_gate #(
  parameter int CNT_W = pit_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             held_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] next_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             boundary_o,
  output logic             pf_o,
  output logic             irq_o
);

  logic fire;

  assign boundary_o = ((next_i & mask_i) == '0);
  assign fire       = step_i & ~held_i & active_i & boundary_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_o  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      pf_o  <= fire;
      irq_o <= fire;
    end
  end

endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
  import pit_pkg::*;
#(
  parameter int CNT_W = DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tb_tick_i,
  input  logic [CODE_W-1:0] rate_sel_i,
  input  logic [CTL_W-1:0]  div_ctl_i,
  input  logic              pie_i,
  output logic              pf_set_o,
  output logic              irq_req_o
);

  logic             hold_w;
  logic             active_w;
  logic             boundary_w;
  logic [CNT_W-1:0] div_count;
  logic [CNT_W-1:0] div_next;
  logic [CNT_W-1:0] tick_mask;

  assign hold_w = div_held(div_ctl_i);

  pit_prescaler #(.CNT_W(CNT_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (tb_tick_i),
    .clear_i (hold_w),
    .count_o (div_count),
    .next_o  (div_next)
  );

  pit_rate_decode #(.CNT_W(CNT_W)) u_dec (
    .code_i   (rate_sel_i),
    .pie_i    (pie_i),
    .active_o (active_w),
    .mask_o   (tick_mask)
  );

  pit_tick_gate #(.CNT_W(CNT_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (tb_tick_i),
    .held_i     (hold_w),
    .active_i   (active_w),
    .next_i     (div_next),
    .mask_i     (tick_mask),
    .boundary_o (boundary_w),
    .pf_o       (pf_set_o),
    .irq_o      (irq_req_o)
  );

endmodule

// File: rtl/periodic_tick_gen_sva.sv
module periodic_tick_gen_sva #(
  parameter int CNT_W = pit_pkg::DIV_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tb_tick_i,
  input logic [3:0]       rate_sel_i,
  input logic             pie_i,
  input logic             hold_w,
  input logic [CNT_W-1:0] div_count,
  input logic [CNT_W-1:0] tick_mask,
  input logic             pf_set_o,
  input logic             irq_req_o
);

  a_r2_code_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i == 4'd0) |=> !pf_set_o);

  a_r6_pie_low_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pie_i |=> !pf_set_o);

  a_r7_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_w |=> (div_count == '0) && !pf_set_o);

  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tb_tick_i && !hold_w) |=> $stable(div_count) && !pf_set_o);

  a_r5_aligned_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_set_o |-> ((div_count & $past(tick_mask)) == '0));

  a_r8_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_set_o |=> !pf_set_o);

  a_r8_irq_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o == pf_set_o);

endmodule

bind periodic_tick_gen periodic_tick_gen_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tb_tick_i  (tb_tick_i),
  .rate_sel_i (rate_sel_i),
  .pie_i      (pie_i),
  .hold_w     (hold_w),
  .div_count  (div_count),
  .tick_mask  (tick_mask),
  .pf_set_o   (pf_set_o),
  .irq_req_o  (irq_req_o)
);

// File: tb/periodic_tick_gen_test.sv
module periodic_tick_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_tick = 1'b0;
  logic [3:0] rate = 4'd0;
  logic [2:0] ctl = 3'b010;
  logic       pie = 1'b0;
  logic       pf, irq;

  item_t q[$];
  int    compared = 0;
  int    mismatched = 0;
  int    model_cnt = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_tick_gen uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tb_tick_i  (tb_tick),
    .rate_sel_i (rate),
    .div_ctl_i  (ctl),
    .pie_i      (pie),
    .pf_set_o   (pf),
    .irq_req_o  (irq)
  );

  // Period in timebase enables; 0 means no ticks at all.
  function automatic int period_of(input int code);
    case (code)
      0:       return 0;
      1:       return 128;
      2:       return 256;
      default: return 2 ** (code - 1);
    endcase
  endfunction

  // Monitor: compare one queued expectation per clock cycle.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compared++;
      if (pf !== it.exp) begin
        mismatched++;
        $display("FAIL %s pf_set: actual %b expected %b at %0t", it.tag, pf, it.exp, $time);
      end
      compared++;
      if (irq !== it.exp) begin
        mismatched++;
        $display("FAIL %s/R8 irq_req: actual %b expected %b at %0t", it.tag, irq, it.exp, $time);
      end
    end
  end

  // Driver: set inputs for n cycles and queue what the next edge should yield.
  task automatic drive(input int n, input int code, input bit en, input logic [2:0] c,
                       input int ce_every, input bit rst_val, input string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      int per;
      bit ce;
      @(negedge clk);
      #1;
      ce      = ((i % ce_every) == 0);
      rst_n   = rst_val;
      tb_tick = ce;
      rate    = 4'(code);
      pie     = en;
      ctl     = c;
      per     = period_of(code);
      it.tag  = tag;
      it.exp  = 1'b0;
      if (!rst_val || c[2:1] == 2'b11) begin
        model_cnt = 0;
      end else if (ce) begin
        model_cnt = (model_cnt + 1) % 32768;
        it.exp = en && per != 0 && (model_cnt % per) == 0;
      end
      q.push_back(it);
    end
  endtask

  initial begin
    drive(5, 3, 1'b1, 3'b010, 1, 1'b0, "R1");
    drive(40, 3, 1'b1, 3'b010, 1, 1'b1, "R1/R3");
    drive(40, 0, 1'b1, 3'b010, 1, 1'b1, "R2");
    drive(300, 1, 1'b1, 3'b010, 1, 1'b1, "R4");
    drive(600, 2, 1'b1, 3'b000, 1, 1'b1, "R4");
    drive(203, 6, 1'b1, 3'b010, 1, 1'b1, "R5");
    drive(200, 4, 1'b1, 3'b100, 1, 1'b1, "R5");
    drive(50, 3, 1'b0, 3'b010, 1, 1'b1, "R6");
    drive(50, 3, 1'b1, 3'b010, 1, 1'b1, "R5");
    drive(20, 5, 1'b1, 3'b110, 1, 1'b1, "R7");
    drive(20, 5, 1'b1, 3'b111, 1, 1'b1, "R7");
    drive(100, 5, 1'b1, 3'b010, 1, 1'b1, "R7");
    drive(90, 3, 1'b1, 3'b010, 3, 1'b1, "R9");
    drive(33000, 15, 1'b1, 3'b010, 1, 1'b1, "R3");
    drive(200, 7, 1'b1, 3'b001, 2, 1'b1, "R3/R9");
    drive(3, 0, 1'b0, 3'b010, 1, 1'b1, "R2");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule